// File: doc/BRIEF.md
# External Interrupt Flag Controller

This block gathers interrupt events for an 8051-style processor. Seven primary interrupt lines each have an input pin, an enable bit and a pending flag. A flag is set once for each qualifying edge of the synchronized pin. It clears on its own when the core acknowledges that line. Each line drives one request output, which is high while the line's flag and its enable are both set.

Seven secondary flags sit alongside the primary ones, each with its own enable:

- transfer busy
- two flash-collision sources
- rising lock of the clock generator
- falling lock of the clock generator
- wake
- pushbutton

Software clears a secondary flag by writing a zero to its bit. Ones written to the flag byte have no effect, so a mask with one zero bit clears exactly that flag. Enabled secondary flags are merged onto primary lines 2, 4 and 6. Prioritising and vectoring the requests is left to the processor.

Top module: `irq_flag_ctrl`

## Requirements
- R1: After reset, every enable and every flag reads 0, `irq_req` is 0, and the polarity register (address 4) reads 8'h03.
- R2: The pin edge that sets a primary flag depends on the line. Lines 0, 1, 5 and 6 set on a falling pin edge. Line 4 sets on a rising pin edge. Lines 2 and 3 set on a falling edge when polarity bit 0 (for line 2) or bit 1 (for line 3) is 1, and on a rising edge when that bit is 0.
- R3: A pin change is seen in the flag after the third rising clock edge. One pin transition sets the flag once. A level that stays at its new value does not set the flag again after it has been cleared.
- R4: `irq_req[i]` is 1 exactly when primary flag i (address 1, bit i) and primary enable i (address 0, bit i) are both 1.
- R5: Driving `ack_valid` with `ack_line`=i clears primary flag i at the next edge. Other flags are untouched. Values 7 and above clear nothing.
- R6: Writes to the primary flag byte (address 1) are ignored.
- R7: Each secondary flag at address 3 is set by its own event, three edges after the event. The bits and their events are:
  - bit 0: rising `sec_src[0]` (transfer busy)
  - bit 1: rising `sec_src[1]` (flash collision A)
  - bit 2: rising `sec_src[2]` (flash collision B)
  - bit 3: rising `sec_src[3]` (lock)
  - bit 4: falling `sec_src[3]` (lock)
  - bit 5: rising `sec_src[4]` (wake)
  - bit 6: rising `sec_src[5]` (pushbutton)
  - bit 7: always reads 0
- R8: A write to address 3 clears every secondary flag whose data bit is 0. A data bit of 1 leaves its flag unchanged.
- R9: Secondary flags are routed onto primary lines:
  - line 2 carries bits 1 and 2.
  - line 4 carries bits 3 and 4.
  - line 6 carries bit 0.
  - bits 5 and 6 are not routed to any line.

  For each line, the OR of (secondary flag AND secondary enable at address 2) is formed. When it goes from 0 to 1, the line's primary flag is set one edge later.
- R10: If a set event and a clear (acknowledge or write-zero) reach the same flag at the same edge, the flag ends up set.
- R11: The registers are addressed as follows:
  - address 0: primary enable, read/write
  - address 1: primary flags, read only
  - address 2: secondary enable, read/write
  - address 3: secondary flags
  - address 4: polarity, bits 1:0
  - addresses 5 to 7: read 0

  Reads are combinational. Writes take effect at the clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ext_irq | input | 7 | Primary interrupt pins, asynchronous |
| sec_src | input | 6 | Secondary event sources, asynchronous |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register address |
| wdata | input | 8 | Register write data |
| rdata | output | 8 | Register read data |
| ack_valid | input | 1 | Interrupt acknowledge strobe |
| ack_line | input | 3 | Line being acknowledged |
| irq_req | output | 7 | Per-line interrupt request |

## Verification
Results fall due at different times after each kind of stimulus:

- **Pin or source change:** reaches a flag after the third rising edge, two synchronizer stages plus the flag register. A secondary event that is enabled reaches its primary flag one edge after that.
- **Register write or acknowledge:** shows at the next edge.
- **Reads:** combinational, so they are valid as soon as the address settles.

The bench drives on the falling clock edge and samples one nanosecond later. Directed checks wait the exact number of falling edges for each path, and check one cycle early as well, where the result must still be absent. The random phase compares every cycle against a bench model that applies these same delays.

// File: rtl/irq_pkg.sv
`timescale 1ns/1ps
// Shared constants for the interrupt flag controller: sizes, register
// addresses, line kinds and the routing of secondary flags onto lines.
package irq_pkg;
    localparam int N_LINES = 7;                    // primary interrupt lines
    localparam int N_SRC   = 6;                    // secondary source pins
    localparam int N_SEC   = 7;                    // secondary flags
    localparam int DATA_W  = 8;                    // register data width
    localparam int ADDR_W  = 3;                    // register address width
    localparam int POL_W   = 2;                    // programmable-polarity lines
    localparam int ACK_W   = $clog2(N_LINES);      // acknowledge line index width
    localparam int PROG_BASE = 2;                  // first programmable line

    typedef enum logic [ADDR_W-1:0] {
        A_PRIM_EN   = 3'd0,
        A_PRIM_FLAG = 3'd1,
        A_SEC_EN    = 3'd2,
        A_SEC_FLAG  = 3'd3,
        A_POL       = 3'd4
    } reg_addr_e;

    // How a primary pin qualifies an edge.
    typedef enum logic [1:0] {
        K_FALL, // falling edge of the pin
        K_RISE, // rising edge of the pin
        K_PROG, // edge chosen by a polarity bit
        K_INV   // pin inverted, then rising edge detected
    } line_kind_e;

    localparam line_kind_e LINE_KIND [N_LINES] =
        '{K_FALL, K_FALL, K_PROG, K_PROG, K_RISE, K_INV, K_INV};

    // Secondary flag bits merged onto each primary line (index = line).
    localparam logic [N_SEC-1:0] SEC_ROUTE [N_LINES] =
        '{7'h00, 7'h00, 7'h06, 7'h00, 7'h18, 7'h00, 7'h01};

    // Secondary flags that set on a falling source edge (lock lost).
    localparam logic [N_SEC-1:0] SEC_FALL_SEL = 7'h10;

    // Pins that are inverted ahead of the synchronizer.
    function automatic logic [N_LINES-1:0] inv_mask();
        logic [N_LINES-1:0] m;
        for (int l = 0; l < N_LINES; l++) m[l] = (LINE_KIND[l] == K_INV);
        return m;
    endfunction
endpackage

// File: rtl/irq_sync_edge.sv
`timescale 1ns/1ps
// Synchronizes W asynchronous inputs through STAGES flops, keeps one more
// registered copy and reports one event per qualifying transition.
// Per bit, fall_sel picks the falling (1) or the rising (0) transition.
// Assumes inputs are stable for at least one clock between transitions.
module irq_sync_edge #(
    parameter int             W       = 7,
    parameter int             STAGES  = 2,
    parameter logic [W-1:0]   RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    input  logic [W-1:0] fall_sel,
    output logic [W-1:0] evt
);
    localparam int LAST = STAGES - 1;

    logic [W-1:0] pipe [STAGES];
    logic [W-1:0] held;

    // Synchronizer chain plus the delayed copy used for edge comparison.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < STAGES; k++) pipe[k] <= RST_VAL;
            held <= RST_VAL;
        end else begin
            pipe[0] <= din;
            for (int k = 1; k < STAGES; k++) pipe[k] <= pipe[k-1];
            held <= pipe[LAST];
        end
    end

    // Edge qualification according to the selected direction.
    always_comb begin
        evt = (pipe[LAST] & ~held & ~fall_sel) | (~pipe[LAST] & held & fall_sel);
    end
endmodule

// File: rtl/irq_cfg_regs.sv
`timescale 1ns/1ps
// Holds the software-written configuration (primary enables, secondary
// enables, polarity of the programmable lines) and multiplexes all
// register bytes onto the read bus. Flag bytes are supplied from outside.
module irq_cfg_regs
    import irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [N_SEC-1:0]  wdata,
    input  logic [N_LINES-1:0] prim_flag,
    input  logic [DATA_W-1:0] sec_byte,
    output logic [N_LINES-1:0] prim_en,
    output logic [N_SEC-1:0]  sec_en,
    output logic [POL_W-1:0]  pol_fall,
    output logic [DATA_W-1:0] rdata
);
    // Configuration register writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prim_en  <= '0;
            sec_en   <= '0;
            pol_fall <= '1;
        end else if (wr_en) begin
            case (addr)
                A_PRIM_EN: prim_en  <= wdata[N_LINES-1:0];
                A_SEC_EN:  sec_en   <= wdata;
                A_POL:     pol_fall <= wdata[POL_W-1:0];
                default: ;
            endcase
        end
    end

    // Read data multiplexer; unused addresses read zero.
    always_comb begin
        rdata = '0;
        case (addr)
            A_PRIM_EN:   rdata[N_LINES-1:0] = prim_en;
            A_PRIM_FLAG: rdata[N_LINES-1:0] = prim_flag;
            A_SEC_EN:    rdata[N_SEC-1:0]   = sec_en;
            A_SEC_FLAG:  rdata              = sec_byte;
            A_POL:       rdata[POL_W-1:0]   = pol_fall;
            default:     rdata              = '0;
        endcase
    end
endmodule

// File: rtl/irq_flag_core.sv
`timescale 1ns/1ps
// Pending-flag storage. Primary flags are set by pin events or by a rising
// merged secondary term, and cleared by acknowledge. Secondary flags are set
// by source events and cleared by write-zero; written ones are ignored.
// A set always wins over a clear on the same edge.
module irq_flag_core
    import irq_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_LINES-1:0] pin_set,
    input  logic [N_SEC-1:0]   sec_set,
    input  logic [N_SEC-1:0]   sec_en,
    input  logic               sec_wr,
    input  logic [DATA_W-1:0]  wdata,
    input  logic               ack_valid,
    input  logic [ACK_W-1:0]   ack_line,
    output logic [N_LINES-1:0] prim_hit,
    output logic [N_LINES-1:0] prim_flag,
    output logic [DATA_W-1:0]  sec_byte
);
    logic [N_LINES-1:0] merged;
    logic [N_LINES-1:0] merged_q;
    logic [N_LINES-1:0] ack_mask;
    logic [DATA_W-1:0]  keep;

    // Merged secondary term per line: any routed flag that is enabled.
    for (genvar l = 0; l < N_LINES; l++) begin : g_merge
        assign merged[l] = |(sec_byte[N_SEC-1:0] & sec_en & SEC_ROUTE[l]);
    end

    // Primary set: pin event or a new rise of the merged secondary term.
    always_comb begin
        prim_hit = pin_set | (merged & ~merged_q);
    end

    // Acknowledge decode; out-of-range line numbers clear nothing.
    always_comb begin
        ack_mask = '0;
        if (ack_valid && (ack_line < ACK_W'(N_LINES)))
            ack_mask = N_LINES'(1) << ack_line;
    end

    // Write-zero-to-clear mask for the secondary byte.
    always_comb begin
        keep = sec_wr ? wdata : '1;
    end

    // Flag registers and the delayed merged term.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prim_flag <= '0;
            sec_byte  <= '0;
            merged_q  <= '0;
        end else begin
            prim_flag <= (prim_flag & ~ack_mask) | prim_hit;
            sec_byte  <= (sec_byte & keep) | DATA_W'(sec_set);
            merged_q  <= merged;
        end
    end
endmodule

// File: rtl/irq_flag_ctrl.sv
`timescale 1ns/1ps
// Top of the external interrupt flag controller. Edge-detects seven primary
// pins and six secondary sources, keeps the pending flags, exposes the
// register port and drives one request per primary line.
// Assumes all pins and sources are asynchronous to clk and clean of glitches.
module irq_flag_ctrl
    import irq_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_LINES-1:0] ext_irq,
    input  logic [N_SRC-1:0]   sec_src,
    input  logic               wr_en,
    input  logic [ADDR_W-1:0]  addr,
    input  logic [DATA_W-1:0]  wdata,
    output logic [DATA_W-1:0]  rdata,
    input  logic               ack_valid,
    input  logic [ACK_W-1:0]   ack_line,
    output logic [N_LINES-1:0] irq_req
);
    localparam logic [N_LINES-1:0] INV_MASK = inv_mask();

    logic [N_LINES-1:0] pin_view;
    logic [N_LINES-1:0] pin_fall_sel;
    logic [N_LINES-1:0] pin_set;
    logic [N_SEC-1:0]   src_view;
    logic [N_SEC-1:0]   sec_set;
    logic [N_LINES-1:0] prim_en;
    logic [N_SEC-1:0]   sec_en;
    logic [POL_W-1:0]   pol_fall;
    logic [N_LINES-1:0] prim_hit;
    logic [N_LINES-1:0] prim_flag;
    logic [DATA_W-1:0]  sec_byte;
    logic               sec_wr;

    // Per-line pin conditioning and edge direction.
    for (genvar l = 0; l < N_LINES; l++) begin : g_line
        if (LINE_KIND[l] == K_PROG) begin : g_prog
            assign pin_fall_sel[l] = pol_fall[l-PROG_BASE];
        end else if (LINE_KIND[l] == K_FALL) begin : g_fall
            assign pin_fall_sel[l] = 1'b1;
        end else begin : g_rise
            assign pin_fall_sel[l] = 1'b0;
        end
        assign pin_view[l] = ext_irq[l] ^ INV_MASK[l];
    end

    // Lock status feeds two flags, so it occupies two detector slots.
    assign src_view = {sec_src[5], sec_src[4], sec_src[3], sec_src[3], sec_src[2:0]};

    assign sec_wr = wr_en && (addr == A_SEC_FLAG);

    irq_sync_edge #(
        .W(N_LINES), .STAGES(SYNC_STAGES), .RST_VAL(INV_MASK)
    ) u_pin_edge (
        .clk(clk), .rst_n(rst_n), .din(pin_view),
        .fall_sel(pin_fall_sel), .evt(pin_set)
    );

    irq_sync_edge #(
        .W(N_SEC), .STAGES(SYNC_STAGES), .RST_VAL('0)
    ) u_src_edge (
        .clk(clk), .rst_n(rst_n), .din(src_view),
        .fall_sel(SEC_FALL_SEL), .evt(sec_set)
    );

    irq_cfg_regs u_cfg (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
        .wdata(wdata[N_SEC-1:0]), .prim_flag(prim_flag), .sec_byte(sec_byte),
        .prim_en(prim_en), .sec_en(sec_en), .pol_fall(pol_fall), .rdata(rdata)
    );

    irq_flag_core u_flags (
        .clk(clk), .rst_n(rst_n), .pin_set(pin_set), .sec_set(sec_set),
        .sec_en(sec_en), .sec_wr(sec_wr), .wdata(wdata),
        .ack_valid(ack_valid), .ack_line(ack_line),
        .prim_hit(prim_hit), .prim_flag(prim_flag), .sec_byte(sec_byte)
    );

    // Request per line: pending and enabled.
    always_comb begin
        irq_req = prim_flag & prim_en;
    end
endmodule

// File: rtl/irq_flag_ctrl_chk.sv
`timescale 1ns/1ps
// Assertion checker for irq_flag_ctrl, attached by bind. Relates the set
// events from the detectors to the flag registers and the clear paths.
module irq_flag_ctrl_chk
    import irq_pkg::*;
(
    input logic               clk,
    input logic               rst_n,
    input logic               wr_en,
    input logic [ADDR_W-1:0]  addr,
    input logic [N_SEC-1:0]   wdata,
    input logic               ack_valid,
    input logic [ACK_W-1:0]   ack_line,
    input logic [N_LINES-1:0] prim_hit,
    input logic [N_LINES-1:0] prim_flag,
    input logic [N_SEC-1:0]   sec_set,
    input logic [N_SEC-1:0]   sec_flag,
    input logic [DATA_W-1:0]  rdata
);
    for (genvar l = 0; l < N_LINES; l++) begin : g_prim
        // R5: acknowledge with no competing set clears the flag.
        assert_ack_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
            (ack_valid && ack_line == ACK_W'(l) && !prim_hit[l]) |=> !prim_flag[l]);
        // R10: a set event always lands, even against an acknowledge.
        assert_set_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
            prim_hit[l] |=> prim_flag[l]);
        // R6: a primary flag only drops after its own acknowledge.
        assert_prim_drop_R6: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(prim_flag[l]) |-> $past(ack_valid && ack_line == ACK_W'(l)));
    end

    for (genvar j = 0; j < N_SEC; j++) begin : g_sec
        // R7: a source event sets its secondary flag.
        assert_sec_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
            sec_set[j] |=> sec_flag[j]);
        // R8: a written one leaves a pending flag alone.
        assert_one_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
            (sec_flag[j] && wr_en && addr == A_SEC_FLAG && wdata[j]) |=> sec_flag[j]);
        // R8: a secondary flag only drops after a zero was written to it.
        assert_sec_drop_R8: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(sec_flag[j]) |-> $past(wr_en && addr == A_SEC_FLAG && !wdata[j]));
    end

    // R7: the unused top bit of the secondary flag byte reads zero.
    assert_top_bit_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (addr == A_SEC_FLAG) |-> !rdata[DATA_W-1]);
endmodule

bind irq_flag_ctrl irq_flag_ctrl_chk u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
    .wdata(wdata[irq_pkg::N_SEC-1:0]), .ack_valid(ack_valid), .ack_line(ack_line),
    .prim_hit(prim_hit), .prim_flag(prim_flag), .sec_set(sec_set),
    .sec_flag(sec_byte[irq_pkg::N_SEC-1:0]), .rdata(rdata)
);

// File: tb/irq_flag_ctrl_tb.sv
`timescale 1ns/1ps
// Self-checking bench: directed corner cases, then seeded random traffic
// compared every cycle with a requirement-level model.
module irq_flag_ctrl_tb;
    import irq_pkg::*;

    logic clk = 1'b0;
    always #2 clk = ~clk;   // 250 MHz

    logic              rst_n = 1'b0;
    logic [6:0]        ext_irq = '0;
    logic [5:0]        sec_src = '0;
    logic              wr_en = 1'b0;
    logic [2:0]        addr = '0;
    logic [7:0]        wdata = '0;
    logic [7:0]        rdata;
    logic              ack_valid = 1'b0;
    logic [2:0]        ack_line = '0;
    logic [6:0]        irq_req;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    irq_flag_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .ext_irq(ext_irq), .sec_src(sec_src),
        .wr_en(wr_en), .addr(addr), .wdata(wdata), .rdata(rdata),
        .ack_valid(ack_valid), .ack_line(ack_line), .irq_req(irq_req)
    );

    // ---------------- requirement-level model ----------------
    logic [6:0] mx1, mx2, mx3;
    logic [5:0] ms1, ms2, ms3;
    logic [6:0] m_pen, m_pflag, m_sen, m_sflag, m_agg_q;
    logic [1:0] m_pol;

    function automatic logic [6:0] f_pin_set(input logic [6:0] now, input logic [6:0] old,
                                             input logic [1:0] pol);
        logic [6:0] r, f, s;
        r = now & ~old;
        f = ~now & old;
        s[0] = f[0];
        s[1] = f[1];
        s[2] = pol[0] ? f[2] : r[2];
        s[3] = pol[1] ? f[3] : r[3];
        s[4] = r[4];
        s[5] = f[5];
        s[6] = f[6];
        return s;
    endfunction

    function automatic logic [6:0] f_sec_set(input logic [5:0] now, input logic [5:0] old);
        logic [5:0] r, f;
        r = now & ~old;
        f = ~now & old;
        return {r[5], r[4], f[3], r[3], r[2], r[1], r[0]};
    endfunction

    function automatic logic [6:0] f_agg(input logic [6:0] fl, input logic [6:0] en);
        logic [6:0] a, x;
        x = fl & en;
        a = '0;
        a[2] = x[1] | x[2];
        a[4] = x[3] | x[4];
        a[6] = x[0];
        return a;
    endfunction

    function automatic logic [7:0] f_rdata(input logic [2:0] a);
        case (a)
            3'd0: return {1'b0, m_pen};
            3'd1: return {1'b0, m_pflag};
            3'd2: return {1'b0, m_sen};
            3'd3: return {1'b0, m_sflag};
            3'd4: return {6'b0, m_pol};
            default: return 8'h00;
        endcase
    endfunction

    always @(posedge clk) begin : model
        logic [6:0] pset, sset, agg, ackm, keep;
        if (!rst_n) begin
            mx1 <= '0; mx2 <= '0; mx3 <= '0;
            ms1 <= '0; ms2 <= '0; ms3 <= '0;
            m_pen <= '0; m_pflag <= '0; m_sen <= '0; m_sflag <= '0;
            m_agg_q <= '0; m_pol <= 2'b11;
        end else begin
            agg  = f_agg(m_sflag, m_sen);
            pset = f_pin_set(mx2, mx3, m_pol) | (agg & ~m_agg_q);
            sset = f_sec_set(ms2, ms3);
            ackm = (ack_valid && ack_line < 3'd7) ? (7'd1 << ack_line) : 7'd0;
            keep = (wr_en && addr == 3'd3) ? wdata[6:0] : 7'h7F;
            mx1 <= ext_irq; mx2 <= mx1; mx3 <= mx2;
            ms1 <= sec_src; ms2 <= ms1; ms3 <= ms2;
            m_agg_q <= agg;
            m_pflag <= (m_pflag & ~ackm) | pset;
            m_sflag <= (m_sflag & keep) | sset;
            if (wr_en) begin
                if (addr == 3'd0) m_pen <= wdata[6:0];
                if (addr == 3'd2) m_sen <= wdata[6:0];
                if (addr == 3'd4) m_pol <= wdata[1:0];
            end
        end
    end

    // ---------------- helpers ----------------
    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] v);
        addr = a;
        #1;
        v = rdata;
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        wr_en = 1'b1; addr = a; wdata = d;
        tick(1);
        wr_en = 1'b0;
    endtask

    task automatic ack(input logic [2:0] l);
        ack_valid = 1'b1; ack_line = l;
        tick(1);
        ack_valid = 1'b0;
    endtask

    // ---------------- watchdog ----------------
    initial begin
        #(4 * 150000);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("  TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end

    // ---------------- stimulus ----------------
    initial begin
        logic [7:0] v;
        void'($urandom(32'h5EED_0017));
        tick(4);
        rst_n = 1'b1;

        // R1 reset state
        rd(3'd4, v); check("R1 polarity", v, 8'h03);
        rd(3'd0, v); check("R1 prim_en", v, 8'h00);
        rd(3'd1, v); check("R1 prim_flag", v, 8'h00);
        rd(3'd3, v); check("R1 sec_flag", v, 8'h00);
        check("R1 irq_req", irq_req, 7'h00);

        // R3 latency on rising line 4
        ext_irq[4] = 1'b1;
        tick(2); rd(3'd1, v); check("R3 not yet", v, 8'h00);
        tick(1); rd(3'd1, v); check("R3 third edge", v, 8'h10);
        tick(3);
        ack(3'd4); rd(3'd1, v); check("R5 ack line4", v, 8'h00);
        tick(5); rd(3'd1, v); check("R3 held level no reset", v, 8'h00);

        // R2 line 0 falling only
        ext_irq[0] = 1'b1; tick(5); rd(3'd1, v); check("R2 line0 rise ignored", v, 8'h00);
        ext_irq[0] = 1'b0; tick(3); rd(3'd1, v); check("R2 line0 fall", v, 8'h01);
        // R2 line 5 falling at source
        ext_irq[5] = 1'b1; tick(5); rd(3'd1, v); check("R2 line5 rise ignored", v, 8'h01);
        ext_irq[5] = 1'b0; tick(3); rd(3'd1, v); check("R2 line5 fall", v, 8'h21);
        // R2 programmable lines
        wr(3'd4, 8'h02); rd(3'd4, v); check("R11 polarity write", v, 8'h02);
        ext_irq[2] = 1'b1; tick(3); rd(3'd1, v); check("R2 line2 rising", v, 8'h25);
        ext_irq[3] = 1'b1; tick(4); rd(3'd1, v); check("R2 line3 rise ignored", v, 8'h25);
        ext_irq[3] = 1'b0; tick(3); rd(3'd1, v); check("R2 line3 falling", v, 8'h2D);

        // R4 requests
        wr(3'd0, 8'h01); #1; check("R4 one enable", irq_req, 7'h01);
        wr(3'd0, 8'h7F); #1; check("R4 all enables", irq_req, 7'h2D);
        // R6 writes to flags ignored
        wr(3'd1, 8'h00); rd(3'd1, v); check("R6 flag write ignored", v, 8'h2D);
        // R5 ack clears only its line; out-of-range ack clears nothing
        ack(3'd0); rd(3'd1, v); check("R5 ack line0", v, 8'h2C);
        ack(3'd7); rd(3'd1, v); check("R5 ack 7 ignored", v, 8'h2C);
        ack(3'd2); ack(3'd3); ack(3'd5);
        rd(3'd1, v); check("R5 all acked", v, 8'h00);

        // R7 secondary events
        sec_src[3] = 1'b1; tick(2); rd(3'd3, v); check("R7 not yet", v, 8'h00);
        tick(1); rd(3'd3, v); check("R7 lock rise", v, 8'h08);
        sec_src[3] = 1'b0; tick(3); rd(3'd3, v); check("R7 lock fall", v, 8'h18);
        sec_src[0] = 1'b1; tick(3); rd(3'd3, v); check("R7 transfer busy", v, 8'h19);
        sec_src[4] = 1'b1; sec_src[5] = 1'b1; tick(3);
        rd(3'd3, v); check("R7 wake and button", v, 8'h79);
        sec_src[1] = 1'b1; sec_src[2] = 1'b1; tick(3);
        rd(3'd3, v); check("R7 collisions", v, 8'h7F);
        rd(3'd1, v); check("R9 disabled sources idle", v, 8'h00);

        // R8 write-zero-to-clear
        wr(3'd3, 8'hFF); rd(3'd3, v); check("R8 ones ignored", v, 8'h7F);
        wr(3'd3, 8'hF7); rd(3'd3, v); check("R8 clear bit3", v, 8'h77);
        wr(3'd3, 8'hF9); rd(3'd3, v); check("R8 clear bits1,2", v, 8'h71);

        // R9 merging
        wr(3'd2, 8'h10); rd(3'd1, v); check("R9 not yet", v, 8'h00);
        tick(1); rd(3'd1, v); check("R9 line4 from lock fall", v, 8'h10);
        wr(3'd2, 8'h70); tick(2); rd(3'd1, v); check("R9 wake/button unrouted", v, 8'h10);
        wr(3'd2, 8'h71); tick(1); rd(3'd1, v); check("R9 line6 from transfer", v, 8'h50);

        // R10 set beats write-zero on a secondary flag
        sec_src[0] = 1'b0; tick(3);
        wr(3'd3, 8'hFE); rd(3'd3, v); check("R8 bit0 cleared", v & 8'h01, 8'h00);
        sec_src[0] = 1'b1; tick(2);
        wr(3'd3, 8'hFE); rd(3'd3, v); check("R10 sec set wins", v & 8'h01, 8'h01);
        // R10 set beats acknowledge on a primary flag
        ext_irq[1] = 1'b1; tick(5);
        ext_irq[1] = 1'b0; tick(2);
        ack(3'd1); rd(3'd1, v); check("R10 prim set wins", v & 8'h02, 8'h02);
        ack(3'd1); rd(3'd1, v); check("R5 second ack", v & 8'h02, 8'h00);

        // R11 unused addresses
        rd(3'd5, v); check("R11 addr5", v, 8'h00);
        rd(3'd6, v); check("R11 addr6", v, 8'h00);
        rd(3'd7, v); check("R11 addr7", v, 8'h00);

        // Random phase against the model
        rst_n = 1'b0; ext_irq = '0; sec_src = '0; tick(3);
        rst_n = 1'b1;
        for (int c = 0; c < 4000; c++) begin
            @(negedge clk);
            for (int b = 0; b < 7; b++) if ($urandom_range(0, 9) == 0) ext_irq[b] = ~ext_irq[b];
            for (int b = 0; b < 6; b++) if ($urandom_range(0, 9) == 0) sec_src[b] = ~sec_src[b];
            wr_en     = ($urandom_range(0, 5) == 0);
            addr      = 3'($urandom_range(0, 7));
            wdata     = 8'($urandom);
            ack_valid = ($urandom_range(0, 3) == 0);
            ack_line  = 3'($urandom_range(0, 7));
            #1;
            check("R4 random irq_req", irq_req, m_pflag & m_pen);
            check("R11 random rdata", rdata, f_rdata(addr));
        end
        wr_en = 1'b0; ack_valid = 1'b0;
        tick(2);

        finished = 1;
        $display("  TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end
endmodule